// File: doc/BRIEF.md
# Grouped vectored interrupt controller

The controller gathers a wide bank of interrupt source lines (192 by default) and sorts them into byte-wide register groups, so that source n sits in group n/8 at bit n%8. Each source line passes through a two-stage synchronizer. Software then chooses, per source, whether the line is sensed by level or by edge, and whether the active sense is high/rising or low/falling. A detected event latches a per-source pending bit. Software clears a pending bit by writing a one to it.

Each source also has an enable bit. Every pending bit that is also enabled feeds one interrupt request line to the processor. A vector byte names the lowest-numbered source that is both pending and enabled, with a fixed offset of 0x10 added. The processor reaches all registers over a simple synchronous byte bus. A write is captured on the rising clock edge when the write strobe is high. Read data follows the address combinationally.

Top module: `grp_irq_ctrl`

## Requirements
- R1: Bus byte addresses: 0..23 hold the pending groups, 24..47 the enable groups, 48..71 the sense-mode groups, 72..95 the polarity groups, and 96 the vector. Source n maps to bit n%8 of group n/8 within each block. Mode and polarity bytes read back what was written.
- R2: After reset, every pending, enable, mode and polarity bit is 0, `irq_req` is low and the vector reads 0x10.
- R3: With mode bit 0 (level) and polarity bit 0, the pending bit is set while the input is high. A clear written while the input is still high leaves it set. Once the input has gone low, the pending bit stays set until it is cleared.
- R4: With mode bit 0 and polarity bit 1, the pending bit is set while the input is low.
- R5: With mode bit 1 (edge) and polarity bit 0, a 0-to-1 input transition sets the pending bit. A steady high input does not set it again after a clear, and a 1-to-0 transition does not set it.
- R6: With mode bit 1 and polarity bit 1, a 1-to-0 transition sets the pending bit, and a 0-to-1 transition does not.
- R7: Writing a pending group clears exactly the bits written as one. Bits written as zero keep their value.
- R8: `irq_req` is high exactly when some source is both pending and enabled. A disabled source still records its pending bit.
- R9: The vector byte equals the lowest-numbered pending-and-enabled source plus 0x10. It reads 0x10 when no such source exists.
- R10: An input change sets the pending bit, and so `irq_req`, on the third rising clock edge after the change and not on the second.
- R11: Writes to the vector address, or to addresses 97 and above, change no register. Reads from addresses 97 and above return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | 192 | Raw interrupt source lines, asynchronous to clk |
| bus_addr | input | 7 | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_req | output | 1 | Request to the processor |

## Verification
The bench clears a level source while its input is still asserted. A design that let the clear win over the live level would drop the request early. It holds an edge source high across a clear and drives edges of the wrong direction. A design that sensed levels in edge mode, or ignored polarity, would re-pend the source or pend it falsely. It leaves several sources pending with different enable masks and reads the vector. A wrong scan order would name the highest source instead of the lowest, and forgetting the offset would give the wrong value, including the 0x10 idle value. It counts the edges between an input change and the pending bit, which catches a missing or extra synchronizer stage. It also shows that a zero written to a pending group clears nothing.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    RG_STAT = 3'd0,
    RG_EN   = 3'd1,
    RG_MODE = 3'd2,
    RG_POL  = 3'd3,
    RG_VEC  = 3'd4,
    RG_NONE = 3'd5
  } irqc_region_e;

  // Which register block a byte address falls into.
  function automatic irqc_region_e region_of(input int unsigned addr,
                                             input int unsigned groups);
    if (addr < groups)          return RG_STAT;
    else if (addr < 2 * groups) return RG_EN;
    else if (addr < 3 * groups) return RG_MODE;
    else if (addr < 4 * groups) return RG_POL;
    else if (addr == 4 * groups) return RG_VEC;
    else                         return RG_NONE;
  endfunction

  // Group index inside a block.
  function automatic int unsigned group_of(input int unsigned addr,
                                           input int unsigned groups);
    return addr % groups;
  endfunction

  // Vector value for a source index.
  function automatic int unsigned vec_code(input int unsigned idx,
                                           input int unsigned offset);
    return idx + offset;
  endfunction

  // Next pending state: a set event wins over a clear.
  function automatic logic pend_next(input logic cur, input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic mode_edge,
  input  logic pol_low,
  input  logic clr,
  output logic set_evt,
  output logic pend
);
  logic prev_q;
  logic pend_q;
  logic lvl_act;
  logic rise;
  logic fall;
  logic edge_hit;

  assign lvl_act  = sync_in ^ pol_low;
  assign rise     = sync_in & ~prev_q;
  assign fall     = ~sync_in & prev_q;
  assign edge_hit = pol_low ? fall : rise;
  assign set_evt  = mode_edge ? edge_hit : lvl_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_in;
      pend_q <= irqc_pkg::pend_next(pend_q, set_evt, clr);
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned N  = 192,
  parameter int unsigned IW = 8
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl import irqc_pkg::*; #(
  parameter int unsigned NUM_GROUPS = 24,
  parameter int unsigned GROUP_W    = 8,
  parameter int unsigned ADDR_W     = 7,
  parameter logic [GROUP_W-1:0] VEC_OFFSET = 8'h10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_GROUPS*GROUP_W-1:0] irq_src,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [GROUP_W-1:0]            bus_wdata,
  output logic [GROUP_W-1:0]            bus_rdata,
  output logic                          irq_req
);
  localparam int unsigned NUM_SRC = NUM_GROUPS * GROUP_W;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);
  localparam int unsigned GRP_W   = $clog2(NUM_GROUPS);

  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] enable_q;
  logic [NUM_SRC-1:0] mode_q;
  logic [NUM_SRC-1:0] pol_q;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] set_evt;
  logic [NUM_SRC-1:0] fire_vec;
  logic [IDX_W-1:0]   fire_idx;
  logic               fire_any;
  logic [GROUP_W-1:0] vec_val;
  irqc_region_e       acc_region;
  logic [GRP_W-1:0]   grp_sel;

  // Address decode
  always_comb begin
    acc_region = region_of(32'(bus_addr), NUM_GROUPS);
    grp_sel    = GRP_W'(group_of(32'(bus_addr), NUM_GROUPS));
  end

  irqc_sync #(.W(NUM_SRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_src),
    .q     (src_sync)
  );

  // Per-group configuration registers and clear masks
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = bus_wr && (grp_sel == GRP_W'(g));

    assign clr_vec[g*GROUP_W +: GROUP_W] =
      (hit && acc_region == RG_STAT) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        enable_q[g*GROUP_W +: GROUP_W] <= '0;
        mode_q[g*GROUP_W +: GROUP_W]   <= '0;
        pol_q[g*GROUP_W +: GROUP_W]    <= '0;
      end else if (hit) begin
        if (acc_region == RG_EN)   enable_q[g*GROUP_W +: GROUP_W] <= bus_wdata;
        if (acc_region == RG_MODE) mode_q[g*GROUP_W +: GROUP_W]   <= bus_wdata;
        if (acc_region == RG_POL)  pol_q[g*GROUP_W +: GROUP_W]    <= bus_wdata;
      end
    end
  end

  // Per-source detection and pending state
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    irqc_src_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_in   (src_sync[n]),
      .mode_edge (mode_q[n]),
      .pol_low   (pol_q[n]),
      .clr       (clr_vec[n]),
      .set_evt   (set_evt[n]),
      .pend      (status_q[n])
    );
  end

  assign fire_vec = status_q & enable_q;

  irqc_prio #(.N(NUM_SRC), .IW(IDX_W)) u_prio (
    .req (fire_vec),
    .idx (fire_idx),
    .any (fire_any)
  );

  assign irq_req = fire_any;
  assign vec_val = GROUP_W'(vec_code(32'(fire_idx), 32'(VEC_OFFSET)));

  // Read mux
  always_comb begin
    unique case (acc_region)
      RG_STAT: bus_rdata = status_q[int'(grp_sel)*GROUP_W +: GROUP_W];
      RG_EN:   bus_rdata = enable_q[int'(grp_sel)*GROUP_W +: GROUP_W];
      RG_MODE: bus_rdata = mode_q[int'(grp_sel)*GROUP_W +: GROUP_W];
      RG_POL:  bus_rdata = pol_q[int'(grp_sel)*GROUP_W +: GROUP_W];
      RG_VEC:  bus_rdata = vec_val;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned N = 192,
  parameter int unsigned W = 8,
  parameter logic [W-1:0] OFFSET = 8'h10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq_req,
  input logic [N-1:0] status_q,
  input logic [N-1:0] enable_q,
  input logic [N-1:0] set_evt,
  input logic [N-1:0] clr_vec,
  input logic [W-1:0] vec_val
);
  // R8
  req_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (|(status_q & enable_q)));

  // R2
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq_req);

  // R9
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (vec_val == OFFSET));

  // R9
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (int'(vec_val) >= int'(OFFSET) && int'(vec_val) < int'(OFFSET) + int'(N)));

  for (genvar n = 0; n < N; n++) begin : g_bit
    // R3
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[n] |=> status_q[n]);

    // R7
    clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[n] && !set_evt[n]) |=> !status_q[n]);

    // R7
    hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[n] && !set_evt[n]) |=> $stable(status_q[n]));
  end
endmodule

bind grp_irq_ctrl irqc_chk #(.N(NUM_SRC), .W(GROUP_W), .OFFSET(VEC_OFFSET)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_req  (irq_req),
  .status_q (status_q),
  .enable_q (enable_q),
  .set_evt  (set_evt),
  .clr_vec  (clr_vec),
  .vec_val  (vec_val)
);

// File: tb/tb_grp_irq_ctrl.sv
`timescale 1ns/100ps
module tb_grp_irq_ctrl;
  localparam int A_ST = 0, A_EN = 24, A_MD = 48, A_PL = 72, A_VEC = 96;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [191:0] irq_src = '0;
  logic [6:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_wdata = '0;
  logic [7:0]   bus_rdata;
  logic         irq_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  grp_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    bus_addr = 7'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 7'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic chk_rd(input string tag, input int a, input int exp);
    int d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset();
    for (int g = 0; g < 24; g++) chk_rd("R2 enable reset", A_EN + g, 0);
    chk_rd("R2 mode reset", A_MD + 3, 0);
    chk_rd("R2 polarity reset", A_PL + 20, 0);
    chk_rd("R2 status reset", A_ST + 0, 0);
    chk("R2 irq_req reset", int'(irq_req), 0);
    chk_rd("R2 vector reset", A_VEC, 'h10);
  endtask

  task automatic t_level_high();
    wr(A_EN + 1, 'h20);
    irq_src[13] = 1'b1;
    cyc(4);
    chk_rd("R3 level set grp1", A_ST + 1, 'h20);
    chk("R3 irq_req", int'(irq_req), 1);
    chk_rd("R9 vector src13", A_VEC, 13 + 'h10);
    wr(A_ST + 1, 'h20);
    cyc(2);
    chk_rd("R3 clear while high", A_ST + 1, 'h20);
    irq_src[13] = 1'b0;
    cyc(4);
    chk_rd("R3 latched after low", A_ST + 1, 'h20);
    wr(A_ST + 1, 'h20);
    chk_rd("R3 cleared", A_ST + 1, 0);
    chk("R3 irq_req low", int'(irq_req), 0);
    wr(A_EN + 1, 0);
  endtask

  task automatic t_level_low();
    wr(A_EN + 12, 'h10);
    wr(A_PL + 12, 'h10);
    cyc(4);
    chk_rd("R4 active-low set", A_ST + 12, 'h10);
    chk_rd("R9 vector src100", A_VEC, 100 + 'h10);
    irq_src[100] = 1'b1;
    cyc(4);
    wr(A_ST + 12, 'h10);
    cyc(3);
    chk_rd("R4 high input inactive", A_ST + 12, 0);
    chk("R4 irq_req low", int'(irq_req), 0);
    wr(A_EN + 12, 0);
    wr(A_PL + 12, 0);
    irq_src[100] = 1'b0;
    cyc(4);
    wr(A_ST + 12, 'hFF);
  endtask

  task automatic t_edge_rise();
    wr(A_MD + 23, 'h80);
    wr(A_EN + 23, 'h80);
    chk_rd("R1 mode readback", A_MD + 23, 'h80);
    irq_src[191] = 1'b1;
    cyc(2);
    chk_rd("R10 not after two edges", A_ST + 23, 0);
    chk("R10 irq_req not yet", int'(irq_req), 0);
    cyc(1);
    chk_rd("R10 set on third edge", A_ST + 23, 'h80);
    chk("R10 irq_req third edge", int'(irq_req), 1);
    wr(A_ST + 23, 'h80);
    cyc(4);
    chk_rd("R5 steady high no re-set", A_ST + 23, 0);
    irq_src[191] = 1'b0;
    cyc(4);
    chk_rd("R5 falling ignored", A_ST + 23, 0);
    wr(A_MD + 23, 0);
    wr(A_EN + 23, 0);
  endtask

  task automatic t_edge_fall();
    wr(A_MD + 0, 'h01);
    wr(A_PL + 0, 'h01);
    cyc(3);
    chk_rd("R6 no set while idle", A_ST + 0, 0);
    irq_src[0] = 1'b1;
    cyc(4);
    chk_rd("R6 rising ignored", A_ST + 0, 0);
    irq_src[0] = 1'b0;
    cyc(4);
    chk_rd("R6 falling sets", A_ST + 0, 'h01);
    wr(A_ST + 0, 'h01);
    chk_rd("R6 cleared", A_ST + 0, 0);
    wr(A_MD + 0, 0);
    wr(A_PL + 0, 0);
  endtask

  task automatic t_w1c();
    wr(A_MD + 4, 'h60);
    irq_src[37] = 1'b1; irq_src[38] = 1'b1;
    cyc(3);
    irq_src[37] = 1'b0; irq_src[38] = 1'b0;
    cyc(4);
    chk_rd("R7 both pending", A_ST + 4, 'h60);
    wr(A_ST + 4, 'h00);
    chk_rd("R7 zero write no effect", A_ST + 4, 'h60);
    wr(A_ST + 4, 'h20);
    chk_rd("R7 clears only bit5", A_ST + 4, 'h40);
    wr(A_ST + 4, 'h40);
    chk_rd("R7 clears bit6", A_ST + 4, 0);
    wr(A_MD + 4, 0);
  endtask

  task automatic t_enable();
    wr(A_MD + 7, 'h04);
    irq_src[58] = 1'b1;
    cyc(3);
    irq_src[58] = 1'b0;
    cyc(4);
    chk_rd("R8 pending while disabled", A_ST + 7, 'h04);
    chk("R8 no request while disabled", int'(irq_req), 0);
    chk_rd("R9 vector idle disabled", A_VEC, 'h10);
    wr(A_EN + 7, 'h04);
    chk("R8 request on enable", int'(irq_req), 1);
    wr(A_EN + 7, 'h00);
    chk("R8 request off on disable", int'(irq_req), 0);
    wr(A_ST + 7, 'h04);
    wr(A_MD + 7, 0);
  endtask

  task automatic t_vector();
    wr(A_MD + 1, 'h20); wr(A_MD + 12, 'h10); wr(A_MD + 23, 'h80);
    irq_src[13] = 1'b1; irq_src[100] = 1'b1; irq_src[191] = 1'b1;
    cyc(3);
    irq_src[13] = 1'b0; irq_src[100] = 1'b0; irq_src[191] = 1'b0;
    cyc(4);
    wr(A_EN + 23, 'h80);
    chk_rd("R9 vector only 191", A_VEC, 191 + 'h10);
    wr(A_EN + 12, 'h10);
    chk_rd("R9 vector lowest 100", A_VEC, 100 + 'h10);
    wr(A_EN + 1, 'h20);
    chk_rd("R9 vector lowest 13", A_VEC, 13 + 'h10);
    wr(A_EN + 1, 0);
    wr(A_ST + 12, 'h10);
    chk_rd("R9 vector after clear", A_VEC, 191 + 'h10);
    wr(A_ST + 23, 'h80);
    chk_rd("R9 vector none", A_VEC, 'h10);
    chk("R9 irq_req none", int'(irq_req), 0);
    wr(A_ST + 1, 'h20);
    wr(A_EN + 12, 0); wr(A_EN + 23, 0);
    wr(A_MD + 1, 0); wr(A_MD + 12, 0); wr(A_MD + 23, 0);
  endtask

  task automatic t_map();
    wr(A_MD + 5, 'hA5);
    chk_rd("R1 mode grp5 readback", A_MD + 5, 'hA5);
    wr(A_PL + 9, 'h3C);
    chk_rd("R1 polarity grp9 readback", A_PL + 9, 'h3C);
    wr(A_PL + 9, 0);
    wr(A_MD + 5, 0);
    wr(A_VEC, 'hFF);
    chk_rd("R11 vector write ignored", A_VEC, 'h10);
    chk_rd("R11 enable grp0 untouched", A_EN + 0, 0);
    wr(110, 'hFF);
    chk_rd("R11 unmapped reads zero", 110, 0);
    chk_rd("R11 status grp14 untouched", A_ST + 14, 0);
    chk_rd("R11 enable grp14 untouched", A_EN + 14, 0);
    chk("R11 no request", int'(irq_req), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_level_high();
    t_level_low();
    t_edge_rise();
    t_edge_fall();
    t_w1c();
    t_enable();
    t_vector();
    t_map();
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule